// File: doc/BRIEF.md
# Wiper Position Register with Stored Recall

This block keeps the 7-bit position of a digitally controlled potentiometer wiper and a stored copy of that position that survives a soft reset. A serial-bus front end hands it write requests, marked as either volatile (wiper only) or stored (wiper and stored copy). It also picks which of the two values appears on the read port. The block turns the current position into a one-hot select across 128 taps. Tap 0 sits at the low end of the resistor string and tap 127 at the high end.

After any reset the wiper first sits at mid-scale, tap 64. It stays there for a recall period while the supplies settle, and then takes the stored position. A stored write changes both values at once and then holds `busy` high for a fixed programming time. This models the long cell write. While `busy` is high the block ignores every write request. The recall and programming times are parameters counted in clock cycles. The stored copy has its own power-on reset, `por_n`. The soft reset `rst_n` leaves it alone.

Top module: `wiper_nv_core`

## Requirements
- R1: While reset is applied, and during the recall period that follows, the wiper position is 64 (binary 1000000) and `busy` is 1.
- R2: Exactly RECALL_CYCLES rising clock edges after reset is released, the wiper takes the stored position and `busy` falls to 0.
- R3: A soft reset (`rst_n` low, `por_n` high) leaves the stored position unchanged, so the recall that follows restores it.
- R4: A write request with `wr_nv`=0 in the idle state sets the wiper from the next edge on and leaves the stored position unchanged.
- R5: A write request with `wr_nv`=1 in the idle state sets both the wiper and the stored position from the next edge on. `busy` then stays 1 for exactly PROG_CYCLES cycles.
- R6: Write requests of either kind are dropped while `busy` is 1, and this includes the last programming cycle and the recall period. Neither register changes.
- R7: Bit 7 of `wr_data` is ignored. Bit 7 of `rd_data` always reads 0.
- R8: `tap_sel` has exactly one bit set, and bit index n is the one set when the position equals n. The index runs from 0 at the low end to 127 at the high end.
- R9: `rd_sel`=0 shows the wiper on `rd_data[6:0]` and `rd_sel`=1 shows the stored position. Selecting either one changes no state.
- R10: Power-on reset (`por_n` low) sets the stored position to NV_RESET, and the recall then loads that value into the wiper.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, async. Clears everything, including the stored position |
| rst_n | input | 1 | Soft reset, active low, async. Clears everything except the stored position |
| wr_en | input | 1 | Write request, one cycle |
| wr_nv | input | 1 | 1: also write the stored position; 0: wiper only |
| wr_data | input | 8 | Write data. Bits 6:0 give the position and bit 7 is ignored |
| rd_sel | input | 1 | Read select: 0 wiper, 1 stored position |
| rd_data | output | 8 | Selected value, with bit 7 always 0 |
| busy | output | 1 | Recall or programming in progress; writes are dropped |
| tap_sel | output | 128 | One-hot tap select |

## Verification
A wrong state value shows at once on `busy`. A recall or programming counter that is off by one moves the falling edge of `busy` by a cycle, and the bench samples that edge exactly. If the stored position is corrupted, the fault is hidden until the next `rd_sel`=1 read or the next recall after a reset. The bench therefore reads the stored value after every write and forces recalls with both reset inputs. A fault in the decoder shows on `tap_sel` in the same cycle as the position it decodes.

// File: rtl/wnv_pkg.sv
package wnv_pkg;
  typedef enum logic [1:0] {
    ST_RECALL = 2'd0,
    ST_IDLE   = 2'd1,
    ST_PROG   = 2'd2
  } wnv_state_e;
endpackage

// File: rtl/wnv_countdown.sv
module wnv_countdown #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/wnv_tap_decode.sv
module wnv_tap_decode #(
  parameter int POS_W = 7,
  localparam int TAPS = 1 << POS_W
) (
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  taps
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    localparam logic [POS_W-1:0] IDX = POS_W'(i);
    assign taps[i] = (pos == IDX);
  end
endmodule

// File: rtl/wiper_nv_core.sv
module wiper_nv_core
  import wnv_pkg::*;
#(
  parameter int               POS_W         = 7,
  parameter int               RECALL_CYCLES = 16,
  parameter int               PROG_CYCLES   = 64,
  parameter logic [POS_W-1:0] NV_RESET      = '0
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_nv,
  input  logic [POS_W:0]           wr_data,
  input  logic                     rd_sel,
  output logic [POS_W:0]           rd_data,
  output logic                     busy,
  output logic [(1<<POS_W)-1:0]    tap_sel
);
  localparam int               MAX_CYC = (RECALL_CYCLES > PROG_CYCLES) ? RECALL_CYCLES : PROG_CYCLES;
  localparam int               CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [POS_W-1:0] MID_POS = POS_W'(1 << (POS_W - 1));
  localparam logic [CNT_W-1:0] PROG_LD = CNT_W'(PROG_CYCLES - 1);

  logic             rst_core_n;
  wnv_state_e       state_q, state_d;
  logic [POS_W-1:0] wiper_q, wiper_d, nv_q, nv_d;
  logic             wiper_en, nv_en, tmr_load, tmr_expired;

  // Either reset clears the volatile side; only power-on clears the stored copy.
  assign rst_core_n = por_n & rst_n;

  wnv_countdown #(
    .CNT_W   (CNT_W),
    .RST_VAL (RECALL_CYCLES - 1)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tmr_load),
    .load_val (PROG_LD),
    .expired  (tmr_expired)
  );

  always_comb begin
    state_d  = state_q;
    wiper_d  = wiper_q;
    nv_d     = nv_q;
    wiper_en = 1'b0;
    nv_en    = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_RECALL: begin
        if (tmr_expired) begin
          state_d  = ST_IDLE;
          wiper_d  = nv_q;
          wiper_en = 1'b1;
        end
      end
      ST_IDLE: begin
        if (wr_en) begin
          wiper_d  = wr_data[POS_W-1:0];
          wiper_en = 1'b1;
          if (wr_nv) begin
            nv_d     = wr_data[POS_W-1:0];
            nv_en    = 1'b1;
            tmr_load = 1'b1;
            state_d  = ST_PROG;
          end
        end
      end
      ST_PROG: begin
        if (tmr_expired) state_d = ST_IDLE;
      end
      default: state_d = ST_RECALL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) state_q <= ST_RECALL;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)   wiper_q <= MID_POS;
    else if (wiper_en) wiper_q <= wiper_d;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     nv_q <= NV_RESET;
    else if (nv_en) nv_q <= nv_d;
  end

  wnv_tap_decode #(.POS_W(POS_W)) u_dec (
    .pos  (wiper_q),
    .taps (tap_sel)
  );

  assign busy    = (state_q != ST_IDLE);
  assign rd_data = {1'b0, rd_sel ? nv_q : wiper_q};
endmodule

// File: rtl/wnv_chk.sv
module wnv_chk
  import wnv_pkg::*;
#(
  parameter int POS_W = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input wnv_state_e            state_q,
  input logic [POS_W-1:0]      wiper_q,
  input logic [POS_W-1:0]      nv_q,
  input logic                  wr_en,
  input logic                  wr_nv,
  input logic [POS_W:0]        wr_data,
  input logic [POS_W:0]        rd_data,
  input logic                  busy,
  input logic [(1<<POS_W)-1:0] tap_sel
);
  localparam logic [POS_W-1:0] MID_POS = POS_W'(1 << (POS_W - 1));

  a_r1_mid_during_recall: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECALL) |-> (wiper_q == MID_POS && busy));

  a_r4_volatile_keeps_nv: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && wr_en && !wr_nv) |=> $stable(nv_q));

  a_r5_nv_write_both: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && wr_en && wr_nv) |=>
      (busy && nv_q == $past(wr_data[POS_W-1:0]) && wiper_q == nv_q));

  a_r6_drop_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && wr_en) |=> ($stable(nv_q) && $stable(wiper_q)));

  a_r7_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[POS_W] == 1'b0);

  a_r8_tap_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_sel) == 1) && tap_sel[wiper_q]);
endmodule

bind wiper_nv_core wnv_chk #(.POS_W(POS_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .state_q (state_q),
  .wiper_q (wiper_q),
  .nv_q    (nv_q),
  .wr_en   (wr_en),
  .wr_nv   (wr_nv),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .busy    (busy),
  .tap_sel (tap_sel)
);

// File: tb/sim_wiper_nv_core.sv
module sim_wiper_nv_core;
  localparam int CLK_PERIOD = 10;
  localparam int R = 8;
  localparam int P = 12;
  localparam logic [6:0] NV_INIT = 7'd5;

  logic         clk = 1'b0;
  logic         por_n, rst_n, wr_en, wr_nv, rd_sel;
  logic [7:0]   wr_data, rd_data;
  logic         busy;
  logic [127:0] tap_sel;

  int errors = 0;
  int checks = 0;
  logic [6:0] exp_nv;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_nv_core #(.POS_W(7), .RECALL_CYCLES(R), .PROG_CYCLES(P), .NV_RESET(NV_INIT)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_nv(wr_nv),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy), .tap_sel(tap_sel)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_both(input string req, input logic [6:0] exp_w, input logic [6:0] exp_s);
    rd_sel = 1'b0; #1;
    check({req, " wiper"}, 128'(rd_data), {120'b0, 1'b0, exp_w});
    rd_sel = 1'b1; #1;
    check({req, " stored"}, 128'(rd_data), {120'b0, 1'b0, exp_s});
    rd_sel = 1'b0;
  endtask

  // R1 R2 R6 R10: full power-on with a write attempted during recall
  task automatic t_power_on;
    @(negedge clk);
    por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 busy in reset", 128'(busy), 128'd1);
    read_both("R1 reset", 7'd64, NV_INIT);
    exp_nv = NV_INIT;
    por_n = 1'b1; rst_n = 1'b1;
    for (int k = 1; k <= R; k++) begin
      @(negedge clk);
      if (k == 2) begin wr_en = 1'b1; wr_nv = 1'b1; wr_data = 8'h11; end
      if (k == 3) wr_en = 1'b0;
      if (k == R - 1) begin
        check("R1 busy in recall", 128'(busy), 128'd1);
        check("R1 mid tap", tap_sel, 128'b1 << 64);
      end
    end
    check("R2 busy falls", 128'(busy), 128'd0);
    read_both("R10 R2 R6 recall", NV_INIT, NV_INIT);
  endtask

  // R4 R7 R8: volatile write
  task automatic t_vol_write(input logic [7:0] val);
    wr_en = 1'b1; wr_nv = 1'b0; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    read_both("R4 R7 volatile", val[6:0], exp_nv);
    check("R8 tap", tap_sel, 128'b1 << val[6:0]);
  endtask

  // R5 R6: stored write with intruding requests, including last prog cycle
  task automatic t_nv_write(input logic [7:0] val);
    wr_en = 1'b1; wr_nv = 1'b1; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    exp_nv = val[6:0];
    check("R5 busy rises", 128'(busy), 128'd1);
    read_both("R5 both written", val[6:0], val[6:0]);
    for (int k = 1; k <= P; k++) begin
      @(negedge clk);
      if (k == 1) begin wr_en = 1'b1; wr_nv = 1'b0; wr_data = 8'h7F; end
      if (k == 2) begin wr_nv = 1'b1; wr_data = 8'h01; end
      if (k == 3) wr_en = 1'b0;
      if (k == P - 1) begin
        check("R5 busy held", 128'(busy), 128'd1);
        wr_en = 1'b1; wr_nv = 1'b0; wr_data = 8'h02;
      end
      if (k == P) wr_en = 1'b0;
    end
    check("R5 busy length", 128'(busy), 128'd0);
    read_both("R6 dropped", val[6:0], val[6:0]);
  endtask

  // R3 R1: soft reset keeps stored copy
  task automatic t_soft_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    read_both("R3 R1 in soft reset", 7'd64, exp_nv);
    rst_n = 1'b1;
    repeat (R - 1) @(negedge clk);
    check("R1 recall busy", 128'(busy), 128'd1);
    @(negedge clk);
    check("R2 recall done", 128'(busy), 128'd0);
    read_both("R3 restored", exp_nv, exp_nv);
  endtask

  // R9: read selection has no side effect
  task automatic t_read_no_effect(input logic [6:0] exp_w);
    for (int k = 0; k < 4; k++) begin
      rd_sel = k[0];
      @(negedge clk);
    end
    read_both("R9 reads", exp_w, exp_nv);
    check("R9 idle", 128'(busy), 128'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; wr_nv = 1'b0;
    wr_data = 8'h00; rd_sel = 1'b0; exp_nv = NV_INIT;
    t_power_on();
    t_vol_write(8'h23);
    t_vol_write(8'h00);
    t_vol_write(8'h7F);
    t_vol_write(8'hC1);
    t_nv_write(8'hB3);
    t_vol_write(8'h10);
    t_soft_reset();
    t_read_no_effect(7'h33);
    t_power_on();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule